// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor. It fetches, decodes, executes and retires one instruction in every clock period. It implements a small fixed-length instruction subset with three word formats: register add and subtract, OR with a zero-extended immediate, word load, word store, branch when equal, and an unconditional region jump. The program counter, a 32-entry register file, the immediate extender, the ALU, a word-addressed program ROM and a word-addressed data RAM all sit inside the core. The program image is supplied as an array parameter when the core is instantiated.

Every state element is written on the falling edge of the clock: the program counter, the register file and the data RAM. Reads from the register file and from both memories are combinational. An instruction therefore settles during the high phase and the low phase of one period, and it commits at the falling edge that ends the high phase. The only external pins are the clock and reset inputs and a set of plain debug outputs. These outputs show the current program counter and the register-file write port, and they let an observer follow every result the core retires. There is no streaming data interface, so no valid/ready handshake or back-pressure applies.

Top module: `sc_core`

## Requirements
- R1: `rst` is synchronous and sampled on the falling edge. While it is high, the program counter, all registers and all data words are cleared, and `dbg_wr_en` stays low.
- R2: An opcode of 0 with function code 0x20 writes rs+rt to register rd. Function code 0x22 writes rs−rt to rd. Both wrap modulo 2^32 and advance the PC by 4.
- R3: Opcode 0x0D writes rs OR {16'h0, imm16} to register rt. Bits [15:0] of the word hold imm16.
- R4: Opcode 0x23 forms the address rs + sign-extended imm16, reads the data word at address bits [DAW+1:2], and writes that word to register rt.
- R5: Opcode 0x2B writes register rt to the data word at the address formed as in R4. It writes no register.
- R6: Opcode 0x04 compares rs and rt by subtraction. When they are equal, the next PC is PC+4+(sign-extended imm16 × 4). Otherwise the next PC is PC+4.
- R7: Opcode 0x02 sets the PC to {(PC+4)[31:28], target[25:0], 2'b00}.
- R8: Register 0 always reads as zero. A write aimed at it changes nothing and does not raise `dbg_wr_en`.
- R9: Any other opcode, and any other function code under opcode 0, changes no register and no data word, and it advances the PC by 4.
- R10: `dbg_pc` changes only at a falling clock edge, never at a rising one.

Field positions: op [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], imm16 [15:0], target [25:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All state is updated on its falling edge. |
| rst | input | 1 | Synchronous reset, active high. |
| dbg_pc | output | 32 | Address of the instruction now executing. |
| dbg_wr_en | output | 1 | High when the current instruction commits a register write at the next falling edge. |
| dbg_wr_idx | output | 5 | Destination register of that write. |
| dbg_wr_data | output | 32 | Value being written. |

## Verification
The assertions assume that reset is held across at least one falling edge before execution starts. They also assume that every program-counter value and every load or store address stays inside the program and data windows, because higher address bits are dropped rather than trapped. The stimulus program meets these conditions. Its base registers and offsets keep all accesses within the first few data words, one store uses a negative offset, and control flow ends in a branch back onto itself, so the PC never leaves the ROM. A reset in the middle of the run then checks that clearing works with state already present.

// File: rtl/sc_core_pkg.sv
`timescale 1ns/1ps
package sc_core_pkg;

  localparam int XLEN = 32;
  localparam int REGS = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_JUMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_fn_e;

  typedef struct packed {
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    wb_from_mem;
    logic    reg_we;
    logic    mem_we;
    logic    is_branch;
    logic    is_jump;
    logic    sign_ext;
    alu_fn_e alu_fn;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  typedef enum logic [1:0] {
    CLS_FUNCT,
    CLS_ADD,
    CLS_SUB,
    CLS_OR
  } alu_cls_e;

  alu_cls_e cls;

  // Main decode: one class per opcode; the ALU class is resolved locally below.
  always_comb begin
    ctrl = '0;
    cls  = CLS_ADD;
    case (op)
      OPC_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_we    = 1'b1;
        cls            = CLS_FUNCT;
      end
      OPC_ORI: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.reg_we   = 1'b1;
        cls           = CLS_OR;
      end
      OPC_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.sign_ext    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_we      = 1'b1;
        cls              = CLS_ADD;
      end
      OPC_STORE: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.sign_ext = 1'b1;
        ctrl.mem_we   = 1'b1;
        cls           = CLS_ADD;
      end
      OPC_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.sign_ext  = 1'b1;
        cls            = CLS_SUB;
      end
      OPC_JUMP: begin
        ctrl.is_jump = 1'b1;
      end
      default: ;
    endcase

    // Local ALU decode
    case (cls)
      CLS_FUNCT: begin
        if (funct == FN_ADD) begin
          ctrl.alu_fn = ALU_ADD;
        end else if (funct == FN_SUB) begin
          ctrl.alu_fn = ALU_SUB;
        end else begin
          ctrl.alu_fn = ALU_ADD;
          ctrl.reg_we = 1'b0;
        end
      end
      CLS_SUB: ctrl.alu_fn = ALU_SUB;
      CLS_OR:  ctrl.alu_fn = ALU_OR;
      default: ctrl.alu_fn = ALU_ADD;
    endcase
  end

  always_comb begin
    AST_ONE_EFFECT_KIND: assert ($onehot0({ctrl.reg_we, ctrl.mem_we, ctrl.is_branch, ctrl.is_jump})); // R9
  end

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
  parameter  int W     = 32,
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [DEPTH];

  always_ff @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

  AST_ZERO_REG_UNWRITTEN: assert property (@(negedge clk) disable iff (rst)
    we |-> (wa != '0)); // R8

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (fn)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_dmem.sv
`timescale 1ns/1ps
module sc_dmem #(
  parameter  int W     = 32,
  parameter  int WORDS = 64,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] idx,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [WORDS];

  always_ff @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
  import sc_core_pkg::*;
#(
  parameter  int          IMEM_WORDS = 64,
  parameter  int          DMEM_WORDS = 64,
  parameter  logic [31:0] PROGRAM [IMEM_WORDS] = '{default: 32'h0},
  localparam int          IAW = $clog2(IMEM_WORDS),
  localparam int          DAW = $clog2(DMEM_WORDS),
  localparam int          RAW = $clog2(REGS)
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] dbg_pc,
  output logic        dbg_wr_en,
  output logic [4:0]  dbg_wr_idx,
  output logic [31:0] dbg_wr_data
);

  logic [XLEN-1:0] pc_q, pc_plus4, pc_next, br_target, jmp_target;
  logic [XLEN-1:0] instr, ext_imm, rs_val, rt_val, alu_b, alu_y, mem_rd, wb_data;
  logic [RAW-1:0]  f_rs, f_rt, f_rd, dest;
  logic [15:0]     f_imm;
  logic            alu_zero, rf_we, dm_we, take_branch;
  ctrl_t           ctrl;
  logic            unused_bits;

  // Fetch
  assign instr = PROGRAM[pc_q[IAW+1:2]];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_imm = instr[15:0];
  assign unused_bits = ^{instr[10:6], alu_y[XLEN-1:DAW+2], alu_y[1:0], pc_q[1:0]};

  sc_decode u_dec (
    .op    (instr[31:26]),
    .funct (instr[5:0]),
    .ctrl  (ctrl)
  );

  assign dest  = ctrl.dst_is_rd ? f_rd : f_rt;
  assign rf_we = ctrl.reg_we && !rst && (dest != '0);
  assign dm_we = ctrl.mem_we && !rst;

  sc_regfile #(.W(XLEN), .DEPTH(REGS)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .ra_a (f_rs),
    .ra_b (f_rt),
    .rd_a (rs_val),
    .rd_b (rt_val),
    .we   (rf_we),
    .wa   (dest),
    .wd   (wb_data)
  );

  // Extender and operand select
  assign ext_imm = ctrl.sign_ext ? {{(XLEN-16){f_imm[15]}}, f_imm} : {{(XLEN-16){1'b0}}, f_imm};
  assign alu_b   = ctrl.b_is_imm ? ext_imm : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .fn   (ctrl.alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  sc_dmem #(.W(XLEN), .WORDS(DMEM_WORDS)) u_dm (
    .clk   (clk),
    .rst   (rst),
    .idx   (alu_y[DAW+1:2]),
    .we    (dm_we),
    .wdata (rt_val),
    .rdata (mem_rd)
  );

  assign wb_data = ctrl.wb_from_mem ? mem_rd : alu_y;

  // Next-address logic
  assign pc_plus4    = pc_q + 32'd4;
  assign br_target   = pc_plus4 + {ext_imm[XLEN-3:0], 2'b00};
  assign jmp_target  = {pc_plus4[XLEN-1:XLEN-4], instr[25:0], 2'b00};
  assign take_branch = ctrl.is_branch && alu_zero;

  always_comb begin
    if (ctrl.is_jump)     pc_next = jmp_target;
    else if (take_branch) pc_next = br_target;
    else                  pc_next = pc_plus4;
  end

  always_ff @(negedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign dbg_pc      = pc_q;
  assign dbg_wr_en   = rf_we;
  assign dbg_wr_idx  = dest;
  assign dbg_wr_data = wb_data;

  AST_RESET_CLEARS_PC: assert property (@(negedge clk)
    rst |=> (pc_q == '0)); // R1

  AST_PLAIN_STEP: assert property (@(negedge clk) disable iff (rst)
    (!ctrl.is_jump && !(ctrl.is_branch && (rs_val == rt_val))) |=> (pc_q == $past(pc_q) + 32'd4)); // R9

  AST_BRANCH_TARGET: assert property (@(negedge clk) disable iff (rst)
    (ctrl.is_branch && (rs_val == rt_val)) |=> (pc_q == $past(pc_q) + 32'd4 + {$past(ext_imm[XLEN-3:0]), 2'b00})); // R6

  AST_JUMP_REGION: assert property (@(negedge clk) disable iff (rst)
    ctrl.is_jump |=> ((pc_q[XLEN-1:XLEN-4] == $past(pc_plus4[XLEN-1:XLEN-4])) && (pc_q[1:0] == 2'b00))); // R7

  AST_STORE_NO_REG_WRITE: assert property (@(negedge clk) disable iff (rst)
    dm_we |-> !rf_we); // R5

endmodule

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;

  localparam int IMEM_WORDS = 64;
  localparam int DMEM_WORDS = 64;
  localparam int DAW        = $clog2(DMEM_WORDS);
  localparam int PERIOD_NS  = 4;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] enc_j(int tgt);
    return {6'h02, 26'(tgt)};
  endfunction

  localparam logic [31:0] PROG [IMEM_WORDS] = '{
    0:  enc_i(13, 0, 1, 'h1234),
    1:  enc_i(13, 0, 2, 'hFFFF),
    2:  enc_r(1, 2, 3, 'h20),
    3:  enc_r(1, 2, 4, 'h22),
    4:  enc_r(0, 1, 5, 'h22),
    5:  enc_i('h2B, 0, 3, 8),
    6:  enc_i(13, 0, 9, 'h20),
    7:  enc_i('h2B, 9, 4, -4),
    8:  enc_i('h23, 0, 6, 8),
    9:  enc_i('h23, 0, 7, 'h1C),
    10: enc_i(13, 1, 0, 'h5555),
    11: enc_r(0, 0, 8, 'h20),
    12: enc_i(4, 6, 3, 2),
    13: enc_i(13, 0, 10, 1),
    14: enc_i(13, 0, 10, 2),
    15: enc_i(4, 1, 2, 5),
    16: 32'hFC00_0000,
    17: enc_r(1, 2, 3, 'h24),
    18: enc_j(20),
    19: enc_i(13, 0, 11, 7),
    20: enc_r(6, 7, 12, 'h22),
    21: enc_i(4, 0, 0, -1),
    default: 32'h0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_idx;
  logic [31:0] dbg_wr_data;

  sc_core #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS), .PROGRAM(PROG)) uut (
    .clk         (clk),
    .rst         (rst),
    .dbg_pc      (dbg_pc),
    .dbg_wr_en   (dbg_wr_en),
    .dbg_wr_idx  (dbg_wr_idx),
    .dbg_wr_data (dbg_wr_data)
  );

  always #(PERIOD_NS / 2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;

  logic [31:0] m_reg [32];
  logic [31:0] m_mem [DMEM_WORDS];
  logic [31:0] m_pc;
  string       m_last_req;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    for (int i = 0; i < DMEM_WORDS; i++) m_mem[i] = '0;
    m_pc = '0;
    m_last_req = "R1";
  endtask

  // Compare the ports with the model's view of the current instruction, then retire it.
  task automatic compare_and_step();
    logic [31:0] ins, sx, addr, wd, nxt;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, dst;
    logic [15:0] imm;
    logic        we, mw;
    string       req;
    ins = PROG[m_pc[7:2]];
    op  = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    fn  = ins[5:0];   imm = ins[15:0];
    sx  = {{16{imm[15]}}, imm};
    addr = m_reg[rs] + sx;
    we = 1'b0; mw = 1'b0; dst = '0; wd = '0; req = "R9";
    nxt = m_pc + 32'd4;
    case (op)
      6'h00: begin
        if (fn == 6'h20) begin req = "R2"; we = 1'b1; dst = rd; wd = m_reg[rs] + m_reg[rt]; end
        else if (fn == 6'h22) begin req = "R2"; we = 1'b1; dst = rd; wd = m_reg[rs] - m_reg[rt]; end
      end
      6'h0D: begin req = "R3"; we = 1'b1; dst = rt; wd = m_reg[rs] | {16'h0, imm}; end
      6'h23: begin req = "R4"; we = 1'b1; dst = rt; wd = m_mem[addr[DAW+1:2]]; end
      6'h2B: begin req = "R5"; mw = 1'b1; end
      6'h04: begin req = "R6"; if (m_reg[rs] == m_reg[rt]) nxt = m_pc + 32'd4 + {sx[29:0], 2'b00}; end
      6'h02: begin req = "R7"; nxt = {nxt[31:28], ins[25:0], 2'b00}; end
      default: ;
    endcase
    if (we && dst == 5'd0) begin we = 1'b0; req = "R8"; end
    check(m_last_req, "pc", dbg_pc, m_pc);
    check(req, "write enable", {31'b0, dbg_wr_en}, {31'b0, we});
    if (we) begin
      check(req, "write index", {27'b0, dbg_wr_idx}, {27'b0, dst});
      check(req, "write data", dbg_wr_data, wd);
      m_reg[dst] = wd;
    end
    if (mw) m_mem[addr[DAW+1:2]] = m_reg[rt];
    m_pc = nxt;
    m_last_req = req;
  endtask

  task automatic run_steps(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      check("R10", "pc at rising edge", dbg_pc, m_pc);
      #1;
      compare_and_step();
    end
  endtask

  task automatic reset_phase(int cycles);
    rst = 1'b1;
    model_reset();
    repeat (cycles) @(posedge clk);
    #1;
    check("R1", "pc in reset", dbg_pc, 32'h0);
    check("R1", "write enable in reset", {31'b0, dbg_wr_en}, 32'h0);
    @(posedge clk);
    rst = 1'b0;
    #1;
    compare_and_step();
  endtask

  initial begin
    reset_phase(3);
    run_steps(27);
    // Reset again with live state, then replay the program from cleared state.
    @(posedge clk);
    #1;
    reset_phase(1);
    run_steps(27);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * PERIOD_NS);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule